// File: doc/BRIEF.md
# Programmable Trigger Sequencer

This block decides when a logic analyzer has seen the event it is looking for. On every sample clock it receives a vector of trigger terms from the term generators. It then steps through a small program of up to sixteen sequence steps. Each step holds three conditions:

- an advance condition,
- a divert condition,
- a store condition.

Each condition picks any subset of the terms and reduces that subset with one of six logic functions. The advance condition has to occur a programmed number of times before its actions take effect. Those actions can:

- raise the trigger flag;
- start or stop either of two timers;
- move the sequence to the following step.

The divert condition sends the sequence to a programmed step. The store condition decides which samples go to capture memory until the trigger fires. After that, every sample is stored.

The control flow has three phases, named in `seq_phase_e`:

- `PH_IDLE` is the state after reset. Nothing is stored and no actions are issued.
- `PH_SEEK` means armed and still waiting for the trigger.
- `PH_FIRED` means the trigger has been raised.

The phase transitions are:

- *arm*: any phase goes to `PH_SEEK`, at step 0, with the occurrence count cleared.
- *fire*: `PH_SEEK` goes to `PH_FIRED` on a full advance whose trigger action is set.
- *hold*: every other cycle keeps the phase.

Inside `PH_SEEK` and `PH_FIRED` the step index moves in three ways:

- *advance*: to step+1, wrapping from the last step to 0.
- *divert*: to the programmed target step.
- *stay*: no change.

The program is loaded through a synchronous register-write port. Writes may happen at any time.

Top module: `trig_sequencer`

## Requirements
- R1: After reset the block is in `PH_IDLE`. There, `trig_out`, `capture_en`, `timer_start` and `timer_stop` are all 0 and `seq_state` is 0. A cycle with `arm` high puts the block in `PH_SEEK` at step 0 with the trigger low and the occurrence count cleared. `arm` takes precedence over every other event in that cycle.
- R2: A condition ANDs the terms with its 8-bit mask and then reduces them. The function code is 3 bits: 0=AND, 1=NAND, 2=OR, 3=NOR, 4=XOR (parity of the selected terms), 5=XNOR, and 6 or 7 = never true. For AND, terms outside the mask count as true.
- R3: With an empty mask, AND, NOR and XNOR are true, and OR, NAND and XOR are false.
- R4: A full advance is declared in the cycle in which the advance condition is true for the N-th time in the current step, where N is the 20-bit limit. The occurrences need not be consecutive. A limit of 0 or 1 fires on the first occurrence.
- R5: The occurrence count clears whenever the step changes and whenever a full advance occurs.
- R6: A full advance whose advance action bit is set moves the step to step+1, and the last step wraps to 0. If the trigger action bit is set, `trig_out` rises on the next clock.
- R7: When the divert condition is true and no full advance occurs, the next step is the step's programmed target.
- R8: When a full advance and a divert occur together, the full advance wins. If the full advance has no advance action bit set, the step holds.
- R9: Before the trigger fires, `capture_en` equals the current step's store condition, combinationally. While `trig_out` is high, `capture_en` is 1.
- R10: Once high, `trig_out` stays high until the next arm.
- R11: In a full-advance cycle, `timer_start[k]` and `timer_stop[k]` are high combinationally for timer k when the matching action bit is set. In every other cycle they are low.
- R12: The write address is {step[3:0], field[1:0]}. The fields are:
  - field 0: advance condition, {fn[10:8], mask[7:0]};
  - field 1: divert condition, with target[14:11] added to the same layout;
  - field 2: store condition, same layout as field 0;
  - field 3: limit[19:0] plus the action bits, where bit 20 = trigger, 21 = advance, 22 = timer0 start, 23 = timer0 stop, 24 = timer1 start, 25 = timer1 stop.
  
  After reset every condition uses code 6 and all limits and actions are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Restart the sequence at step 0 with the trigger low |
| cfg_wr_en | input | 1 | Program write strobe |
| cfg_wr_addr | input | 6 | {step, field} write address |
| cfg_wr_data | input | 26 | Write data, layout per field |
| terms | input | 8 | Trigger term vector for this sample |
| trig_out | output | 1 | Trigger/run flag |
| capture_en | output | 1 | Store this sample |
| timer_start | output | 2 | Start pulse per timer |
| timer_stop | output | 2 | Stop pulse per timer |
| seq_state | output | 4 | Current step index |

## Verification
A corrupted step index shows at `seq_state` on the next clock. It also shows in the same cycle as a `capture_en` value taken from the wrong step's store condition. An occurrence count that fails to clear on a step change makes a later advance happen early. That error appears at `seq_state` exactly one clock too soon, which is why the vectors re-enter a step and count its occurrences again. A wrong phase shows as `trig_out` dropping without an arm, or as `capture_en` falling while the trigger is high. Both are visible on the very next sample.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    typedef enum logic [2:0] {
        CF_AND  = 3'd0,
        CF_NAND = 3'd1,
        CF_OR   = 3'd2,
        CF_NOR  = 3'd3,
        CF_XOR  = 3'd4,
        CF_XNOR = 3'd5,
        CF_OFF6 = 3'd6,
        CF_OFF7 = 3'd7
    } cond_fn_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SEEK  = 2'd1,
        PH_FIRED = 2'd2
    } seq_phase_e;

    // action bit positions above the limit field
    localparam int ACT_TRIG   = 0;
    localparam int ACT_ADV    = 1;
    localparam int ACT_T0_ON  = 2;
    localparam int ACT_T0_OFF = 3;
    localparam int ACT_T1_ON  = 4;
    localparam int ACT_T1_OFF = 5;
    localparam int ACT_W      = 6;

    // condition slots
    localparam int SLOT_ADV   = 0;
    localparam int SLOT_DIV   = 1;
    localparam int SLOT_STORE = 2;
    localparam int NSLOT      = 3;

endpackage

// File: rtl/trig_cond_eval.sv
module trig_cond_eval
    import trig_seq_pkg::*;
#(
    parameter int NT = 8
) (
    input  logic [NT-1:0] terms,
    input  logic [NT-1:0] mask,
    input  logic [2:0]    fn,
    output logic          match
);
    logic [NT-1:0] sel;
    logic all_set, any_set, parity;

    always_comb begin
        sel     = terms & mask;
        all_set = &(sel | ~mask);
        any_set = |sel;
        parity  = ^sel;
        unique case (cond_fn_e'(fn))
            CF_AND:  match = all_set;
            CF_NAND: match = ~all_set;
            CF_OR:   match = any_set;
            CF_NOR:  match = ~any_set;
            CF_XOR:  match = parity;
            CF_XNOR: match = ~parity;
            default: match = 1'b0;
        endcase
    end

    // R3: an empty selection reduces to fixed values
    always_comb begin
        if (mask == '0 && fn == 3'(CF_OR)) assert (!match) else $error("p_empty_or_r3");
        if (mask == '0 && fn == 3'(CF_AND)) assert (match) else $error("p_empty_and_r3");
    end
endmodule

// File: rtl/trig_cfg_store.sv
module trig_cfg_store
    import trig_seq_pkg::*;
#(
    parameter int NT = 8,
    parameter int NS = 16,
    parameter int CW = 20,
    parameter int SW = 4,
    parameter int DW = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SW+1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [SW-1:0]           rd_state,
    output logic [NSLOT-1:0][NT-1:0] cond_mask,
    output logic [NSLOT-1:0][2:0]    cond_fn,
    output logic [SW-1:0]           div_target,
    output logic [CW-1:0]           limit,
    output logic [ACT_W-1:0]        actions
);
    localparam int CondW = NT + 3;

    logic [CondW-1:0] cond_q [NSLOT][NS];
    logic [SW-1:0]    tgt_q  [NS];
    logic [CW-1:0]    lim_q  [NS];
    logic [ACT_W-1:0] act_q  [NS];

    logic [1:0]    wr_field;
    logic [SW-1:0] wr_state;
    assign wr_field = wr_addr[1:0];
    assign wr_state = wr_addr[SW+1:2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) begin
                for (int c = 0; c < NSLOT; c++) cond_q[c][s] <= {3'(CF_OFF6), {NT{1'b0}}};
                tgt_q[s] <= '0;
                lim_q[s] <= '0;
                act_q[s] <= '0;
            end
        end else if (wr_en) begin
            if (wr_field == 2'd3) begin
                lim_q[wr_state] <= wr_data[CW-1:0];
                act_q[wr_state] <= wr_data[CW+ACT_W-1:CW];
            end else begin
                cond_q[wr_field][wr_state] <= wr_data[CondW-1:0];
                if (wr_field == 2'd1) tgt_q[wr_state] <= wr_data[CondW+SW-1:CondW];
            end
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign cond_mask[g] = cond_q[g][rd_state][NT-1:0];
        assign cond_fn[g]   = cond_q[g][rd_state][CondW-1:NT];
    end
    assign div_target = tgt_q[rd_state];
    assign limit      = lim_q[rd_state];
    assign actions    = act_q[rd_state];
endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
    import trig_seq_pkg::*;
#(
    parameter int NUM_TERMS  = 8,
    parameter int NUM_STATES = 16,
    parameter int CNT_W      = 20,
    localparam int SW = $clog2(NUM_STATES),
    localparam int AW = SW + 2,
    localparam int DW = (CNT_W + ACT_W > NUM_TERMS + 3 + SW) ? CNT_W + ACT_W : NUM_TERMS + 3 + SW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm,
    input  logic                 cfg_wr_en,
    input  logic [AW-1:0]        cfg_wr_addr,
    input  logic [DW-1:0]        cfg_wr_data,
    input  logic [NUM_TERMS-1:0] terms,
    output logic                 trig_out,
    output logic                 capture_en,
    output logic [1:0]           timer_start,
    output logic [1:0]           timer_stop,
    output logic [SW-1:0]        seq_state
);
    seq_phase_e phase_q, phase_d;
    logic [SW-1:0]    state_q, state_d;
    logic [CNT_W-1:0] occ_q, occ_d;
    logic [CNT_W:0]   occ_next;

    logic [NSLOT-1:0][NUM_TERMS-1:0] cond_mask;
    logic [NSLOT-1:0][2:0]           cond_fn;
    logic [NSLOT-1:0]                match;
    logic [SW-1:0]    div_target;
    logic [CNT_W-1:0] limit;
    logic [ACT_W-1:0] act;
    logic active, adv_now, div_now, full_hit;
    logic [SW-1:0] step_plus;

    trig_cfg_store #(.NT(NUM_TERMS), .NS(NUM_STATES), .CW(CNT_W), .SW(SW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
        .wr_data(cfg_wr_data), .rd_state(state_q), .cond_mask(cond_mask),
        .cond_fn(cond_fn), .div_target(div_target), .limit(limit), .actions(act)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_cond
        trig_cond_eval #(.NT(NUM_TERMS)) u_eval (
            .terms(terms), .mask(cond_mask[g]), .fn(cond_fn[g]), .match(match[g])
        );
    end

    assign active    = (phase_q != PH_IDLE);
    assign adv_now   = active && match[SLOT_ADV];
    assign div_now   = active && match[SLOT_DIV];
    assign occ_next  = {1'b0, occ_q} + 1'b1;
    assign full_hit  = adv_now && (occ_next >= {1'b0, limit});
    assign step_plus = (state_q == SW'(NUM_STATES - 1)) ? '0 : state_q + 1'b1;

    // next-state logic
    always_comb begin
        phase_d = phase_q;
        state_d = state_q;
        occ_d   = occ_q;
        if (arm) begin
            phase_d = PH_SEEK;
            state_d = '0;
            occ_d   = '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: ;
                PH_SEEK, PH_FIRED: begin
                    if (full_hit) begin
                        if (act[ACT_TRIG]) phase_d = PH_FIRED;
                        if (act[ACT_ADV])  state_d = step_plus;
                        occ_d = '0;
                    end else if (div_now) begin
                        state_d = div_target;
                        occ_d   = '0;
                    end else if (adv_now) begin
                        occ_d = occ_next[CNT_W-1:0];
                    end
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            state_q <= '0;
            occ_q   <= '0;
        end else begin
            phase_q <= phase_d;
            state_q <= state_d;
            occ_q   <= occ_d;
        end
    end

    // outputs
    always_comb begin
        trig_out    = (phase_q == PH_FIRED);
        seq_state   = state_q;
        timer_start = full_hit ? {act[ACT_T1_ON],  act[ACT_T0_ON]}  : 2'b00;
        timer_stop  = full_hit ? {act[ACT_T1_OFF], act[ACT_T0_OFF]} : 2'b00;
        unique case (phase_q)
            PH_SEEK:  capture_en = match[SLOT_STORE];
            PH_FIRED: capture_en = 1'b1;
            default:  capture_en = 1'b0;
        endcase
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> (!capture_en && timer_start == 2'b00 && timer_stop == 2'b00));
    p_arm_home_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (seq_state == '0 && !trig_out && occ_q == '0));
    p_occ_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d != state_q) |=> (occ_q == '0));
    p_adv_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full_hit && act[ACT_ADV] && !arm) |=>
        (seq_state == (($past(seq_state) == SW'(NUM_STATES - 1)) ? '0 : $past(seq_state) + 1'b1)));
    p_hit_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full_hit && !act[ACT_ADV] && !arm) |=> $stable(seq_state));
    p_cap_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> capture_en);
    p_trig_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && !arm) |=> trig_out);
    p_pulse_only_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_start != 2'b00 || timer_stop != 2'b00) |-> adv_now);
endmodule

// File: tb/tb_trig_sequencer.sv
module tb_trig_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic cfg_wr_en = 1'b0;
    logic [5:0] cfg_wr_addr = '0;
    logic [25:0] cfg_wr_data = '0;
    logic [7:0] terms = '0;
    logic trig_out, capture_en;
    logic [1:0] timer_start, timer_stop;
    logic [3:0] seq_state;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    trig_sequencer dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data), .terms(terms),
        .trig_out(trig_out), .capture_en(capture_en), .timer_start(timer_start),
        .timer_stop(timer_stop), .seq_state(seq_state)
    );

    typedef struct packed {
        logic [7:0] t;
        logic       cap;
        logic       ts0;
        logic [3:0] st;
        logic       trg;
    } vec_t;

    // terms, capture_en before edge, timer_start[0] before edge, step after edge, trig after edge
    localparam vec_t VEC [11] = '{
        '{8'h00, 1'b0, 1'b0, 4'd0, 1'b0},
        '{8'h83, 1'b1, 1'b0, 4'd0, 1'b0},
        '{8'h01, 1'b0, 1'b0, 4'd0, 1'b0},
        '{8'h03, 1'b0, 1'b0, 4'd0, 1'b0},
        '{8'h03, 1'b0, 1'b0, 4'd1, 1'b0},
        '{8'h10, 1'b1, 1'b0, 4'd0, 1'b0},
        '{8'h03, 1'b0, 1'b0, 4'd0, 1'b0},
        '{8'h03, 1'b0, 1'b0, 4'd0, 1'b0},
        '{8'h03, 1'b0, 1'b0, 4'd1, 1'b0},
        '{8'h14, 1'b1, 1'b1, 4'd2, 1'b1},
        '{8'h00, 1'b1, 1'b0, 4'd2, 1'b1}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [25:0] cond(logic [2:0] fn, logic [7:0] mask, logic [3:0] tgt);
        return 26'({tgt, fn, mask});
    endfunction

    function automatic logic [25:0] actw(logic [5:0] a, logic [19:0] lim);
        return {a, lim};
    endfunction

    task automatic wr(logic [3:0] st, logic [1:0] fld, logic [25:0] d);
        cfg_wr_en = 1'b1; cfg_wr_addr = {st, fld}; cfg_wr_data = d;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
    endtask

    task automatic do_arm();
        arm = 1'b1;
        @(posedge clk); #1;
        arm = 1'b0;
    endtask

    task automatic capchk(string req, logic [2:0] fn, logic [7:0] mask, logic [7:0] t, logic exp);
        wr(4'd0, 2'd2, cond(fn, mask, 4'd0));
        terms = t; #1;
        check(req, 32'(capture_en), 32'(exp));
        terms = 8'h00;
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        terms = 8'hFF; #1;
        // R1 reset state
        check("R1 trig", 32'(trig_out), 0);
        check("R1 capture", 32'(capture_en), 0);
        check("R1 timers", 32'({timer_start, timer_stop}), 0);
        @(posedge clk); #1;
        check("R1 step idle", 32'(seq_state), 0);
        terms = 8'h00;

        // R12 program through the write port
        wr(4'd0, 2'd0, cond(3'd0, 8'h03, 4'd0));   // AND of bits 0,1
        wr(4'd0, 2'd2, cond(3'd2, 8'h80, 4'd0));   // OR of bit 7
        wr(4'd0, 2'd3, actw(6'b000010, 20'd3));    // advance, limit 3
        wr(4'd1, 2'd0, cond(3'd4, 8'h0C, 4'd0));   // XOR of bits 2,3
        wr(4'd1, 2'd1, cond(3'd0, 8'h10, 4'd0));   // divert to 0 on bit 4
        wr(4'd1, 2'd2, cond(3'd3, 8'h01, 4'd0));   // NOR of bit 0
        wr(4'd1, 2'd3, actw(6'b000111, 20'd1));    // trig, advance, timer0 start
        do_arm();
        check("R1 armed step", 32'(seq_state), 0);
        check("R1 armed trig", 32'(trig_out), 0);

        // R4 R5 R6 R7 R8 R9 R11 vector walk
        for (int i = 0; i < 11; i++) begin
            terms = VEC[i].t; #1;
            check($sformatf("R9 cap v%0d", i), 32'(capture_en), 32'(VEC[i].cap));
            check($sformatf("R11 t0start v%0d", i), 32'(timer_start[0]), 32'(VEC[i].ts0));
            @(posedge clk); #1;
            check($sformatf("R4 R5 R7 R8 step v%0d", i), 32'(seq_state), 32'(VEC[i].st));
            check($sformatf("R6 R10 trig v%0d", i), 32'(trig_out), 32'(VEC[i].trg));
        end
        terms = 8'h00;

        // R10 sticky until rearm, then cleared
        check("R10 still set", 32'(trig_out), 1);
        do_arm();
        check("R10 rearm clears", 32'(trig_out), 0);
        check("R1 rearm step", 32'(seq_state), 0);

        // R2 functions with selected terms
        capchk("R2 and true", 3'd0, 8'h03, 8'h03, 1'b1);
        capchk("R2 and false", 3'd0, 8'h03, 8'h01, 1'b0);
        capchk("R2 nand", 3'd1, 8'h03, 8'h01, 1'b1);
        capchk("R2 or", 3'd2, 8'h30, 8'h20, 1'b1);
        capchk("R2 nor", 3'd3, 8'h30, 8'h20, 1'b0);
        capchk("R2 xor", 3'd4, 8'h07, 8'h07, 1'b1);
        capchk("R2 xnor", 3'd5, 8'h07, 8'h07, 1'b0);
        capchk("R2 off", 3'd6, 8'h00, 8'hFF, 1'b0);
        // R3 empty selection
        capchk("R3 and empty", 3'd0, 8'h00, 8'h5A, 1'b1);
        capchk("R3 or empty", 3'd2, 8'h00, 8'h5A, 1'b0);
        capchk("R3 xor empty", 3'd4, 8'h00, 8'h5A, 1'b0);
        capchk("R3 nand empty", 3'd1, 8'h00, 8'h5A, 1'b0);
        capchk("R3 nor empty", 3'd3, 8'h00, 8'h5A, 1'b1);
        capchk("R3 xnor empty", 3'd5, 8'h00, 8'h5A, 1'b1);

        // R4 limit 0 fires on first occurrence
        wr(4'd0, 2'd3, actw(6'b000010, 20'd0));
        terms = 8'h03; #1;
        @(posedge clk); #1;
        terms = 8'h00;
        check("R4 limit zero", 32'(seq_state), 1);

        // R6 wrap, R7 divert to 15, R11 timer1 stop
        wr(4'd15, 2'd0, cond(3'd0, 8'h00, 4'd0));
        wr(4'd15, 2'd3, actw(6'b100010, 20'd1));
        wr(4'd0, 2'd1, cond(3'd0, 8'h00, 4'd15));
        do_arm();
        check("R1 arm wins", 32'(seq_state), 0);
        @(posedge clk); #1;
        check("R7 divert target", 32'(seq_state), 15);
        check("R11 t1 stop", 32'(timer_stop), 32'(2'b10));
        check("R11 no start", 32'(timer_start), 0);
        @(posedge clk); #1;
        check("R6 wrap", 32'(seq_state), 0);
        check("R6 no trig action", 32'(trig_out), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule